// File: doc/BRIEF.md
# Least-Attained-Service Thread Ranking Unit

This block is the central ranking engine shared by several memory controllers. Over each long, fixed-length quantum, every controller counts how much service it gave each thread. At the quantum boundary, each controller hands its per-thread counts to this unit through its own valid/ready port. The unit adds the reports across controllers and divides each thread's total by a power-of-two weight set by software. It then blends the result into a long-term history value using a programmable smoothing factor, and sorts the threads by that history. The outcome is one rank vector, which every controller applies for the whole next quantum.

Threads that have received less smoothed service get a more favourable rank. The sort runs over several cycles as a sequential compare-and-swap pass. The published ranking does not change until a one-cycle done pulse announces the new vector. Thread count, controller count, counter width, history width, smoothing precision and weight width are parameters.

Top module: `las_rank_unit`

## Requirements
- R1: After reset, `rank_vec` is the identity (thread t has rank t), `rank_done` is low and every bit of `rpt_ready` is high.
- R2: Each controller's report is taken exactly once per quantum, on the clock edge where its valid and ready are both high. After that edge its ready stays low, and any data it presents is ignored, until `rank_done` has pulsed.
- R3: A thread's quantum service is the sum of the counts reported for it by all controllers. A controller's count for thread t sits at `rpt_cnt[(c*NTHR+t)*CW +: CW]`, and full-scale counts from every controller are summed without loss.
- R4: Before smoothing, a thread's quantum service is shifted right by its weight field `thr_weight[t*WW +: WW]`. A larger weight therefore favours the thread.
- R5: At each quantum boundary a thread's history becomes floor((alpha*H + (2^AW - alpha)*S) / 2^AW). Here alpha is the `alpha` input, H is the old history (zero after reset) and S is the weighted quantum service.
- R6: Field `rank_vec[t*IW +: IW]` holds thread t's rank, where 0 is the most favoured. Lower history gives a smaller rank. Equal histories are ordered by ascending thread index, so the vector is always a permutation.
- R7: `rank_done` is high for exactly one cycle. It is seen 3 + (NTHR-1)^2 clock edges after the edge that accepts the last report of the quantum.
- R8: `rank_vec` changes only on the edge that raises `rank_done`, and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alpha | input | AW | Smoothing factor, fraction of 2^AW given to history |
| thr_weight | input | NTHR*WW | Per-thread right-shift applied to quantum service |
| rpt_valid | input | NCTL | Per-controller report valid |
| rpt_ready | output | NCTL | Per-controller report ready |
| rpt_cnt | input | NCTL*NTHR*CW | Per-controller, per-thread service counts |
| rank_vec | output | NTHR*IW | Rank of each thread, 0 most favoured |
| rank_done | output | 1 | One-cycle pulse when a new rank vector is published |

## Verification
A wrong history register only shows up as a wrong ordering. It becomes visible on the `rank_done` edge of the quantum it corrupts, or in a later quantum if the smoothing carries the error forward. For this reason the bench keeps its own history values and recomputes the full permutation after every quantum. It compares `rank_vec` on every cycle, so a vector that moves without a done pulse is caught on the next cycle. A sorter or handshake stuck in the wrong state appears as a missing or late pulse, which is measured against the fixed latency, or as a ready that reopens early and lets ignored data leak into the sums.

// File: rtl/las_pkg.sv
package las_pkg;
  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_UPDATE  = 2'd1,
    ST_SORT    = 2'd2,
    ST_FINISH  = 2'd3
  } rank_state_e;
endpackage

// File: rtl/las_accum.sv
// Collects one report per controller and sums counts per thread.
module las_accum #(
  parameter int NTHR = 4,
  parameter int NCTL = 2,
  parameter int CW   = 12,
  parameter int SW   = 13
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   open_i,
  input  logic                   clear_i,
  input  logic [NCTL-1:0]        valid_i,
  input  logic [NCTL*NTHR*CW-1:0] cnt_i,
  output logic [NCTL-1:0]        ready_o,
  output logic                   all_in_o,
  output logic [NTHR*SW-1:0]     sum_o
);
  logic [NCTL-1:0] got_q, got_d, take;
  logic [SW-1:0]   sum_q [NTHR];
  logic [SW-1:0]   sum_d [NTHR];
  logic            en;

  always_comb begin
    ready_o = open_i ? ~got_q : '0;
    take    = valid_i & ready_o;
    got_d   = got_q | take;
    for (int t = 0; t < NTHR; t++) begin
      sum_d[t] = sum_q[t];
      for (int c = 0; c < NCTL; c++) begin
        if (take[c]) sum_d[t] = sum_d[t] + SW'(cnt_i[(c*NTHR+t)*CW +: CW]);
      end
    end
    if (clear_i) begin
      got_d = '0;
      for (int t = 0; t < NTHR; t++) sum_d[t] = '0;
    end
    en = clear_i | (|take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got_q <= '0;
      for (int t = 0; t < NTHR; t++) sum_q[t] <= '0;
    end else if (en) begin
      got_q <= got_d;
      for (int t = 0; t < NTHR; t++) sum_q[t] <= sum_d[t];
    end
  end

  assign all_in_o = &got_q;

  for (genvar t = 0; t < NTHR; t++) begin : g_pack
    assign sum_o[t*SW +: SW] = sum_q[t];
  end
endmodule

// File: rtl/las_history.sv
// Weighted, exponentially smoothed per-thread history.
module las_history #(
  parameter int NTHR = 4,
  parameter int SW   = 13,
  parameter int HW   = 16,
  parameter int AW   = 8,
  parameter int WW   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_i,
  input  logic [AW-1:0]      alpha_i,
  input  logic [NTHR*WW-1:0] weight_i,
  input  logic [NTHR*SW-1:0] sum_i,
  output logic [NTHR*HW-1:0] hist_next_o
);
  localparam int PW  = HW + AW + 1;
  localparam int ONE = 1 << AW;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [SW-1:0] eff;
    logic [PW-1:0] mix;
    logic [HW-1:0] h_q;

    assign eff = sum_i[t*SW +: SW] >> weight_i[t*WW +: WW];
    assign mix = PW'(alpha_i) * PW'(h_q)
               + (PW'(ONE) - PW'(alpha_i)) * PW'(eff);
    assign hist_next_o[t*HW +: HW] = HW'(mix >> AW);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     h_q <= '0;
      else if (upd_i) h_q <= hist_next_o[t*HW +: HW];
    end
  end
endmodule

// File: rtl/las_sorter.sv
// Sequential bubble sort, one compare-and-swap per cycle.
module las_sorter #(
  parameter int NTHR = 4,
  parameter int HW   = 16,
  parameter int IW   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [NTHR*HW-1:0] key_i,
  output logic               last_o,
  output logic [NTHR*IW-1:0] rank_o
);
  localparam logic [IW-1:0] LASTP = IW'(NTHR - 2);

  logic [HW-1:0] key_q [NTHR];
  logic [HW-1:0] key_d [NTHR];
  logic [IW-1:0] idx_q [NTHR];
  logic [IW-1:0] idx_d [NTHR];
  logic [IW-1:0] pos_q, pos_d, pass_q, pass_d;
  logic          run_q, run_d, en;

  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      key_d[t] = key_q[t];
      idx_d[t] = idx_q[t];
    end
    pos_d  = pos_q;
    pass_d = pass_q;
    run_d  = run_q;
    last_o = run_q && (pos_q == LASTP) && (pass_q == LASTP);
    if (load_i) begin
      for (int t = 0; t < NTHR; t++) begin
        key_d[t] = key_i[t*HW +: HW];
        idx_d[t] = IW'(t);
      end
      pos_d  = '0;
      pass_d = '0;
      run_d  = 1'b1;
    end else if (run_q) begin
      for (int p = 0; p < NTHR-1; p++) begin
        if (pos_q == IW'(p)) begin
          if ((key_q[p] > key_q[p+1]) ||
              ((key_q[p] == key_q[p+1]) && (idx_q[p] > idx_q[p+1]))) begin
            key_d[p]   = key_q[p+1];
            key_d[p+1] = key_q[p];
            idx_d[p]   = idx_q[p+1];
            idx_d[p+1] = idx_q[p];
          end
        end
      end
      if (pos_q == LASTP) begin
        pos_d  = '0;
        pass_d = pass_q + 1'b1;
        if (pass_q == LASTP) run_d = 1'b0;
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end
    en = load_i | run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NTHR; t++) begin
        key_q[t] <= '0;
        idx_q[t] <= IW'(t);
      end
      pos_q  <= '0;
      pass_q <= '0;
      run_q  <= 1'b0;
    end else if (en) begin
      for (int t = 0; t < NTHR; t++) begin
        key_q[t] <= key_d[t];
        idx_q[t] <= idx_d[t];
      end
      pos_q  <= pos_d;
      pass_q <= pass_d;
      run_q  <= run_d;
    end
  end

  always_comb begin
    rank_o = '0;
    for (int p = 0; p < NTHR; p++) begin
      rank_o[int'(idx_q[p])*IW +: IW] = IW'(p);
    end
  end
endmodule

// File: rtl/las_rank_unit.sv
module las_rank_unit
  import las_pkg::*;
#(
  parameter int NTHR = 4,
  parameter int NCTL = 2,
  parameter int CW   = 12,
  parameter int HW   = 16,
  parameter int AW   = 8,
  parameter int WW   = 4,
  localparam int IW  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           alpha,
  input  logic [NTHR*WW-1:0]      thr_weight,
  input  logic [NCTL-1:0]         rpt_valid,
  output logic [NCTL-1:0]         rpt_ready,
  input  logic [NCTL*NTHR*CW-1:0] rpt_cnt,
  output logic [NTHR*IW-1:0]      rank_vec,
  output logic                    rank_done
);
  localparam int SW = CW + $clog2(NCTL);

  rank_state_e          state_q, state_d;
  logic                 upd, done_d, done_q, all_in, sort_last;
  logic [NTHR*SW-1:0]   sums;
  logic [NTHR*HW-1:0]   hist_next;
  logic [NTHR*IW-1:0]   sort_rank, rank_q;

  las_accum #(.NTHR(NTHR), .NCTL(NCTL), .CW(CW), .SW(SW)) u_accum (
    .clk(clk), .rst_n(rst_n),
    .open_i(state_q == ST_COLLECT), .clear_i(upd),
    .valid_i(rpt_valid), .cnt_i(rpt_cnt),
    .ready_o(rpt_ready), .all_in_o(all_in), .sum_o(sums)
  );

  las_history #(.NTHR(NTHR), .SW(SW), .HW(HW), .AW(AW), .WW(WW)) u_hist (
    .clk(clk), .rst_n(rst_n), .upd_i(upd),
    .alpha_i(alpha), .weight_i(thr_weight), .sum_i(sums),
    .hist_next_o(hist_next)
  );

  las_sorter #(.NTHR(NTHR), .HW(HW), .IW(IW)) u_sort (
    .clk(clk), .rst_n(rst_n), .load_i(upd), .key_i(hist_next),
    .last_o(sort_last), .rank_o(sort_rank)
  );

  always_comb begin
    state_d = state_q;
    upd     = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      ST_COLLECT: if (all_in) state_d = ST_UPDATE;
      ST_UPDATE: begin
        upd     = 1'b1;
        state_d = ST_SORT;
      end
      ST_SORT:   if (sort_last) state_d = ST_FINISH;
      ST_FINISH: begin
        done_d  = 1'b1;
        state_d = ST_COLLECT;
      end
      default:   state_d = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_COLLECT;
      done_q  <= 1'b0;
      for (int t = 0; t < NTHR; t++) rank_q[t*IW +: IW] <= IW'(t);
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (done_d) rank_q <= sort_rank;
    end
  end

  assign rank_vec  = rank_q;
  assign rank_done = done_q;
endmodule

// File: rtl/las_rank_chk.sv
module las_rank_chk #(
  parameter int NTHR = 4,
  parameter int NCTL = 2,
  parameter int IW   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NCTL-1:0]    rpt_valid,
  input logic [NCTL-1:0]    rpt_ready,
  input logic [NTHR*IW-1:0] rank_vec,
  input logic               rank_done
);
  localparam int MW = 1 << IW;
  logic [MW-1:0] seen;

  always_comb begin
    seen = '0;
    for (int t = 0; t < NTHR; t++) seen[rank_vec[t*IW +: IW]] = 1'b1;
  end

  // R2: an accepted report closes that controller's port
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rpt_valid & rpt_ready)) |=> ((rpt_ready & $past(rpt_valid & rpt_ready)) == '0));

  // R6: published ranking is a permutation
  p_rank_perm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rank_done |-> (seen == ((MW'(1) << NTHR) - MW'(1))));

  // R7: done lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rank_done |=> !rank_done);

  // R8: ranking holds between done pulses
  p_rank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rank_done |-> $stable(rank_vec));
endmodule

bind las_rank_unit las_rank_chk #(.NTHR(NTHR), .NCTL(NCTL), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .rpt_ready(rpt_ready),
  .rank_vec(rank_vec), .rank_done(rank_done)
);

// File: tb/tb_las_rank_unit.sv
module tb_las_rank_unit;
  localparam int NT = 4, NC = 2, CW = 12, HW = 16, AW = 8, WW = 4, IW = 2;
  localparam int LAT = 4 + (NT-1)*(NT-1);

  logic clk, rst_n;
  logic [AW-1:0]         alpha;
  logic [NT*WW-1:0]      thr_weight;
  logic [NC-1:0]         rpt_valid, rpt_ready;
  logic [NC*NT*CW-1:0]   rpt_cnt;
  logic [NT*IW-1:0]      rank_vec;
  logic                  rank_done;

  las_rank_unit #(.NTHR(NT), .NCTL(NC), .CW(CW), .HW(HW), .AW(AW), .WW(WW)) dut (
    .clk(clk), .rst_n(rst_n), .alpha(alpha), .thr_weight(thr_weight),
    .rpt_valid(rpt_valid), .rpt_ready(rpt_ready), .rpt_cnt(rpt_cnt),
    .rank_vec(rank_vec), .rank_done(rank_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int  checks = 0, fails = 0;
  bit  mon_on = 0, pend = 0, ended = 0;
  int  since = 0;
  int  hist_m [NT];
  int  exp_rank [NT];
  int  pend_rank [NT];
  int  cnt_m [NC][NT];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // reference: sums, weights, smoothing, ordering
  task automatic model_quantum();
    int s, e;
    for (int t = 0; t < NT; t++) begin
      s = 0;
      for (int c = 0; c < NC; c++) s += cnt_m[c][t];
      e = s >> thr_weight[t*WW +: WW];
      hist_m[t] = (int'(alpha) * hist_m[t] + ((1 << AW) - int'(alpha)) * e) >> AW;
    end
    for (int t = 0; t < NT; t++) begin
      pend_rank[t] = 0;
      for (int u = 0; u < NT; u++)
        if (hist_m[u] < hist_m[t] || (hist_m[u] == hist_m[t] && u < t)) pend_rank[t]++;
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      since++;
      if (rank_done) begin
        chk(pend, "R7 unexpected done", 1, 0);
        chk(since == LAT, "R7 done latency", since, LAT);
        for (int t = 0; t < NT; t++) exp_rank[t] = pend_rank[t];
        pend = 0;
      end
      for (int t = 0; t < NT; t++)
        chk(int'(rank_vec[t*IW +: IW]) == exp_rank[t], "R6/R8 rank",
            int'(rank_vec[t*IW +: IW]), exp_rank[t]);
    end
  end

  task automatic send(input int c, input int a0, input int a1, input int a2, input int a3);
    @(negedge clk);
    cnt_m[c][0] = a0; cnt_m[c][1] = a1; cnt_m[c][2] = a2; cnt_m[c][3] = a3;
    for (int t = 0; t < NT; t++) rpt_cnt[(c*NT+t)*CW +: CW] = CW'(cnt_m[c][t]);
    rpt_valid[c] = 1'b1;
    while (!rpt_ready[c]) @(negedge clk);
    @(posedge clk);
    #1 rpt_valid[c] = 1'b0;
  endtask

  task automatic wait_done();
    since = 0;
    model_quantum();
    pend = 1;
    while (pend) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(input int a, input int w0, input int w1, input int w2, input int w3);
    @(negedge clk);
    alpha = AW'(a);
    thr_weight = {WW'(w3), WW'(w2), WW'(w1), WW'(w0)};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 0; alpha = '0; thr_weight = '0; rpt_valid = '0; rpt_cnt = '0;
    for (int t = 0; t < NT; t++) begin hist_m[t] = 0; exp_rank[t] = t; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int t = 0; t < NT; t++)
      chk(int'(rank_vec[t*IW +: IW]) == t, "R1 identity rank", int'(rank_vec[t*IW +: IW]), t);
    chk(rank_done == 1'b0, "R1 done low", int'(rank_done), 0);
    chk(rpt_ready == 2'b11, "R1 ready high", int'(rpt_ready), 3);
    mon_on = 1;

    // R3/R5: basic sums, alpha=0.5
    set_cfg(128, 0, 0, 0, 0);
    fork
      send(0, 100, 50, 300, 10);
      send(1, 20, 200, 0, 5);
    join
    wait_done();

    // R6 ties by index, alpha=0
    set_cfg(0, 0, 0, 0, 0);
    fork
      send(0, 40, 40, 7, 40);
      send(1, 0, 0, 33, 0);
    join
    wait_done();

    // R4 weight shift favours thread 0
    set_cfg(0, 3, 0, 0, 0);
    send(0, 800, 100, 200, 300);
    send(1, 0, 0, 0, 0);
    wait_done();

    // R5 heavy history weighting, truncation
    set_cfg(240, 0, 0, 0, 0);
    fork
      send(0, 2000, 0, 0, 0);
      send(1, 0, 100, 100, 100);
    join
    wait_done();

    // R3 full-scale counts from both controllers
    set_cfg(0, 0, 0, 0, 0);
    fork
      send(0, 4095, 4095, 4095, 0);
      send(1, 4095, 0, 4095, 0);
    join
    wait_done();

    // R2 repeat report ignored while port closed
    set_cfg(0, 0, 0, 0, 0);
    send(0, 5, 6, 7, 8);
    @(negedge clk);
    rpt_cnt[0 +: NT*CW] = {CW'(0), CW'(0), CW'(0), CW'(4095)};
    rpt_valid[0] = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(rpt_ready[0] == 1'b0, "R2 port closed", int'(rpt_ready[0]), 0);
      chk(rpt_ready[1] == 1'b1, "R2 other port open", int'(rpt_ready[1]), 1);
    end
    send(1, 0, 0, 0, 0);
    rpt_valid[0] = 1'b0;
    wait_done();

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule